// File: doc/BRIEF.md
# Debug Access Port Control Block

This block sits behind a debug port and takes each register access the debug port forwards. A port-select byte chooses the target. Value 0x00 belongs to the system-bus access port, and this block only flags it. Value 0x01 belongs to this block, which then uses a bank nibble and a two-bit register address to pick a register. The block holds three registers: a control register, a status register and a fixed identification register.

The control register makes three requests. The first is a mass erase of flash, handled as a handshake with the flash controller. The second forces the debug logic off. The third halts the core. A secure input limits which control bits a debugger may change. An erase-enable input decides whether a mass-erase request is passed on to the flash controller. When erase is not allowed, the erase bit is kept set so that the refusal stays visible until reset.

Top module: `dap_ctrl_top`

## Requirements
- R1: On a synchronous reset (`rst_n` low at a clock edge), all control bits clear to 0. `erase_req`, `debug_off`, `halt_req` and `rdata` read 0 after that edge.
- R2: `sysbus_sel` is high in any cycle where `acc_valid` is high and `port_sel` is 0x00. Such an access changes no register of this block.
- R3: A read at port 0x01, bank 0xF, address 3 returns 0x001C0020. A write to that location changes nothing.
- R4: Read data is registered. `rdata` holds the value of the register read in the cycle after a read access (`acc_valid` high, `acc_write` low), and is 0 in the cycle after any cycle with no read. The control register is at port 0x01, bank 0x0, address 1, and reads back as bit0 erase, bit1 debug-off, bit2 halt, with all other bits 0.
- R5: Writing 1 to control bit0 while bit0 is 0 and `erase_enable` is high sets bit0. It also raises `erase_req` for exactly one cycle after that write edge. Writing 1 while bit0 is already 1 raises no new pulse.
- R6: An `erase_done` pulse while a permitted erase is in progress clears control bit0. A written 0 never clears bit0.
- R7: Writing 1 to bit0 while `erase_enable` is low sets bit0 and raises no `erase_req`. Bit0 then stays 1, even through `erase_done`, until reset.
- R8: With `secure` low, a control write copies data bit1 to `debug_off` and data bit2 to `halt_req`. Both outputs change after the write edge.
- R9: With `secure` high, a control write leaves bits 1 and 2 unchanged. Bit0 can still be set.
- R10: The status register (port 0x01, bank 0x0, address 0) reads bit0 = erase in progress (control bit0), bit1 = `secure`, bit2 = `erase_enable`, with all other bits 0.
- R11: An access to any other port, bank or address reads 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| port_sel | input | 8 | Access port select |
| bank_sel | input | 4 | Register bank select |
| reg_addr | input | 2 | Register address within bank |
| wdata | input | 32 | Write data |
| erase_done | input | 1 | Mass-erase completion pulse from flash controller |
| erase_enable | input | 1 | Mass erase permitted |
| secure | input | 1 | Device secured |
| rdata | output | 32 | Registered read data |
| sysbus_sel | output | 1 | Access routed to the system-bus access port |
| erase_req | output | 1 | One-cycle mass-erase request |
| debug_off | output | 1 | Force debug logic off |
| halt_req | output | 1 | Core halt request |

## Verification
The hardest situation to reach is a refused erase that then meets an `erase_done` pulse, with secure writes arriving while the erase bit is stuck. The erase bit can only return to 0 through reset, so random traffic alone stays stuck in that state. The stimulus therefore uses directed sequences that set bit0 with erase disabled, pulse `erase_done` and then reset. It also mixes periodic resets into a seeded random stream that toggles `secure` and `erase_enable` between accesses, so both permitted and refused erases keep recurring.

// File: rtl/dap_pkg.sv
package dap_pkg;
    localparam int DATA_W  = 32;
    localparam int PORT_W  = 8;
    localparam int BANK_W  = 4;
    localparam int RADDR_W = 2;
    localparam int CTRL_W  = 3;

    localparam logic [PORT_W-1:0]  SYS_PORT  = 8'h00;
    localparam logic [PORT_W-1:0]  OWN_PORT  = 8'h01;
    localparam logic [BANK_W-1:0]  REG_BANK  = 4'h0;
    localparam logic [BANK_W-1:0]  ID_BANK   = 4'hF;
    localparam logic [RADDR_W-1:0] ST_ADDR   = 2'd0;
    localparam logic [RADDR_W-1:0] CT_ADDR   = 2'd1;
    localparam logic [RADDR_W-1:0] ID_ADDR   = 2'd3;
    localparam logic [DATA_W-1:0]  ID_VALUE  = 32'h001C_0020;

    localparam int BIT_ERASE = 0;
    localparam int BIT_DBGOFF = 1;
    localparam int BIT_HALT  = 2;
    localparam int ST_BUSY   = 0;
    localparam int ST_SECURE = 1;
    localparam int ST_ENABLE = 2;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CTRL,
        SEL_IDENT
    } reg_sel_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              blocked;
        logic              req;
    } ctrl_state_t;
endpackage

// File: rtl/dap_addr_decode.sv
module dap_addr_decode
    import dap_pkg::*;
#(
    parameter int                  P_W  = PORT_W,
    parameter int                  B_W  = BANK_W,
    parameter int                  A_W  = RADDR_W,
    parameter logic [PORT_W-1:0]   SYSP = SYS_PORT,
    parameter logic [PORT_W-1:0]   OWNP = OWN_PORT
) (
    input  logic           acc_valid,
    input  logic           acc_write,
    input  logic [P_W-1:0] port_sel,
    input  logic [B_W-1:0] bank_sel,
    input  logic [A_W-1:0] reg_addr,
    output logic           sysbus_sel,
    output logic           wr_ctrl,
    output logic           rd_en,
    output reg_sel_e       sel
);
    logic own_hit;

    always_comb begin
        own_hit    = acc_valid && (port_sel == OWNP);
        sysbus_sel = acc_valid && (port_sel == SYSP);
        sel        = SEL_NONE;
        if (own_hit) begin
            if (bank_sel == REG_BANK && reg_addr == ST_ADDR)      sel = SEL_STATUS;
            else if (bank_sel == REG_BANK && reg_addr == CT_ADDR) sel = SEL_CTRL;
            else if (bank_sel == ID_BANK && reg_addr == ID_ADDR)  sel = SEL_IDENT;
        end
        wr_ctrl = acc_valid && acc_write && (sel == SEL_CTRL);
        rd_en   = acc_valid && !acc_write;
    end
endmodule

// File: rtl/dap_ctrl_regs.sv
module dap_ctrl_regs
    import dap_pkg::*;
#(
    parameter int                W = CTRL_W,
    parameter logic [CTRL_W-1:0] SECURE_WMASK = 3'b001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic [W-1:0] wbits,
    input  logic         secure,
    input  logic         erase_enable,
    input  logic         erase_done,
    output logic [W-1:0] ctrl,
    output logic         blocked,
    output logic         erase_req
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (erase_done && st_q.ctrl[BIT_ERASE] && !st_q.blocked)
            st_d.ctrl[BIT_ERASE] = 1'b0;
        if (wr_ctrl) begin
            if (wbits[BIT_ERASE] && !st_q.ctrl[BIT_ERASE]) begin
                st_d.ctrl[BIT_ERASE] = 1'b1;
                st_d.blocked         = !erase_enable;
                st_d.req             = erase_enable;
            end
            for (int b = 1; b < W; b++) begin
                if (!secure || SECURE_WMASK[b])
                    st_d.ctrl[b] = wbits[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl      = st_q.ctrl;
    assign blocked   = st_q.blocked;
    assign erase_req = st_q.req;
endmodule

// File: rtl/dap_read_mux.sv
module dap_read_mux
    import dap_pkg::*;
#(
    parameter int                DW = DATA_W,
    parameter int                CW = CTRL_W,
    parameter logic [DATA_W-1:0] IDV = ID_VALUE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  reg_sel_e      sel,
    input  logic [CW-1:0] ctrl,
    input  logic          secure,
    input  logic          erase_enable,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_STATUS: begin
                    rdata_d[ST_BUSY]   = ctrl[BIT_ERASE];
                    rdata_d[ST_SECURE] = secure;
                    rdata_d[ST_ENABLE] = erase_enable;
                end
                SEL_CTRL:  rdata_d[CW-1:0] = ctrl;
                SEL_IDENT: rdata_d = IDV;
                default:   rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dap_ctrl_top.sv
module dap_ctrl_top
    import dap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [PORT_W-1:0]  port_sel,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               erase_done,
    input  logic               erase_enable,
    input  logic               secure,
    output logic [DATA_W-1:0]  rdata,
    output logic               sysbus_sel,
    output logic               erase_req,
    output logic               debug_off,
    output logic               halt_req
);
    logic              wr_ctrl;
    logic              rd_en;
    reg_sel_e          sel;
    logic [CTRL_W-1:0] ctrl_bits;
    logic              erase_blocked;

    dap_addr_decode u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .port_sel  (port_sel),
        .bank_sel  (bank_sel),
        .reg_addr  (reg_addr),
        .sysbus_sel(sysbus_sel),
        .wr_ctrl   (wr_ctrl),
        .rd_en     (rd_en),
        .sel       (sel)
    );

    dap_ctrl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wbits       (wdata[CTRL_W-1:0]),
        .secure      (secure),
        .erase_enable(erase_enable),
        .erase_done  (erase_done),
        .ctrl        (ctrl_bits),
        .blocked     (erase_blocked),
        .erase_req   (erase_req)
    );

    dap_read_mux u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .sel         (sel),
        .ctrl        (ctrl_bits),
        .secure      (secure),
        .erase_enable(erase_enable),
        .rdata       (rdata)
    );

    assign debug_off = ctrl_bits[BIT_DBGOFF];
    assign halt_req  = ctrl_bits[BIT_HALT];
endmodule

// File: rtl/dap_ctrl_checker.sv
module dap_ctrl_checker
    import dap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [PORT_W-1:0]  port_sel,
    input logic [BANK_W-1:0]  bank_sel,
    input logic [RADDR_W-1:0] reg_addr,
    input logic               erase_done,
    input logic               secure,
    input logic [DATA_W-1:0]  rdata,
    input logic               sysbus_sel,
    input logic               erase_req,
    input logic               debug_off,
    input logic               halt_req,
    input logic [CTRL_W-1:0]  ctrl_bits,
    input logic               erase_blocked
);
    p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    p_req_sets_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> ctrl_bits[BIT_ERASE]);

    p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_done && ctrl_bits[BIT_ERASE] && !erase_blocked) |=> !ctrl_bits[BIT_ERASE]);

    p_blocked_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits[BIT_ERASE] && erase_blocked) |=> ctrl_bits[BIT_ERASE]);

    p_blocked_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_blocked |-> !erase_req);

    p_secure_dbg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(secure)) |-> $stable(debug_off));

    p_secure_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(secure)) |-> $stable(halt_req));

    p_sysbus_noeffect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sysbus_sel && !erase_done) |=> $stable(ctrl_bits));

    p_idle_rdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> (rdata == '0));

    p_ident_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && port_sel == OWN_PORT && bank_sel == ID_BANK
         && reg_addr == ID_ADDR) |=> (rdata == ID_VALUE));
endmodule

bind dap_ctrl_top dap_ctrl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .port_sel     (port_sel),
    .bank_sel     (bank_sel),
    .reg_addr     (reg_addr),
    .erase_done   (erase_done),
    .secure       (secure),
    .rdata        (rdata),
    .sysbus_sel   (sysbus_sel),
    .erase_req    (erase_req),
    .debug_off    (debug_off),
    .halt_req     (halt_req),
    .ctrl_bits    (ctrl_bits),
    .erase_blocked(erase_blocked)
);

// File: tb/tb_dap_ctrl_top.sv
`timescale 1ns/1ps
module tb_dap_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0]  port_sel = '0;
    logic [3:0]  bank_sel = '0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] wdata = '0;
    logic        erase_done = 1'b0, erase_enable = 1'b0, secure = 1'b0;
    logic [31:0] rdata;
    logic        sysbus_sel, erase_req, debug_off, halt_req;

    int checks = 0, failures = 0;
    logic [2:0] m_ctrl;
    logic       m_blk;

    always #2.5 clk = ~clk;

    dap_ctrl_top dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] p, input logic [3:0] b,
                                              input logic [1:0] a);
        if (p == 8'h01 && b == 4'h0 && a == 2'd0) return {29'd0, erase_enable, secure, m_ctrl[0]};
        if (p == 8'h01 && b == 4'h0 && a == 2'd1) return {29'd0, m_ctrl};
        if (p == 8'h01 && b == 4'hF && a == 2'd3) return 32'h001C_0020;
        return 32'd0;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_ctrl = '0; m_blk = 1'b0;
    endtask

    // One access; returns read data and erase_req seen in the following cycle,
    // plus the bench-computed expectations.
    task automatic acc(input logic wr, input logic [7:0] p, input logic [3:0] b,
                       input logic [1:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic rq,
                       output logic [31:0] erd, output logic erq);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; port_sel = p; bank_sel = b; reg_addr = a; wdata = d;
        erd = wr ? 32'd0 : exp_read(p, b, a);
        erq = 1'b0;
        if (wr && p == 8'h01 && b == 4'h0 && a == 2'd1) begin
            if (d[0] && !m_ctrl[0]) begin
                m_ctrl[0] = 1'b1; m_blk = !erase_enable; erq = erase_enable;
            end
            if (!secure) m_ctrl[2:1] = d[2:1];
        end
        #1;
        chk("R2 sysbus_sel", {31'd0, sysbus_sel}, {31'd0, p == 8'h00});
        @(negedge clk);
        rd = rdata; rq = erase_req;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
        if (m_ctrl[0] && !m_blk) m_ctrl[0] = 1'b0;
    endtask

    task automatic chk_outs(input string req);
        chk(req, {30'd0, halt_req, debug_off}, {30'd0, m_ctrl[2], m_ctrl[1]});
    endtask

    logic [31:0] rd, erd;
    logic        rq, erq;
    bit          done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_ctrl = '0; m_blk = 1'b0;
        do_reset();
        // R1 reset state
        @(negedge clk);
        chk("R1 outputs", {28'd0, erase_req, debug_off, halt_req, 1'b0}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        acc(0, 8'h01, 4'h0, 2'd1, 0, rd, rq, erd, erq); chk("R1 ctrl read", rd, 32'd0);

        // R3 identification
        acc(0, 8'h01, 4'hF, 2'd3, 0, rd, rq, erd, erq); chk("R3 id", rd, 32'h001C_0020);
        acc(1, 8'h01, 4'hF, 2'd3, 32'hFFFF_FFFF, rd, rq, erd, erq);
        acc(0, 8'h01, 4'hF, 2'd3, 0, rd, rq, erd, erq); chk("R3 id after write", rd, 32'h001C_0020);
        acc(0, 8'h01, 4'h0, 2'd1, 0, rd, rq, erd, erq); chk("R3 ctrl untouched", rd, 32'd0);

        // R5 permitted erase
        erase_enable = 1'b1;
        acc(1, 8'h01, 4'h0, 2'd1, 32'h1, rd, rq, erd, erq); chk("R5 req pulse", {31'd0, rq}, 32'd1);
        @(negedge clk); chk("R5 req one cycle", {31'd0, erase_req}, 32'd0);
        acc(0, 8'h01, 4'h0, 2'd0, 0, rd, rq, erd, erq); chk("R10 status busy", rd, 32'h5);
        acc(1, 8'h01, 4'h0, 2'd1, 32'h1, rd, rq, erd, erq); chk("R5 no repeat pulse", {31'd0, rq}, 32'd0);
        acc(1, 8'h01, 4'h0, 2'd1, 32'h0, rd, rq, erd, erq);
        acc(0, 8'h01, 4'h0, 2'd1, 0, rd, rq, erd, erq); chk("R6 zero write keeps bit0", rd, 32'h1);
        pulse_done();
        acc(0, 8'h01, 4'h0, 2'd1, 0, rd, rq, erd, erq); chk("R6 done clears", rd, 32'h0);

        // R7 refused erase
        erase_enable = 1'b0;
        acc(1, 8'h01, 4'h0, 2'd1, 32'h1, rd, rq, erd, erq); chk("R7 no req", {31'd0, rq}, 32'd0);
        pulse_done();
        acc(0, 8'h01, 4'h0, 2'd1, 0, rd, rq, erd, erq); chk("R7 bit0 sticks", rd, 32'h1);
        erase_enable = 1'b1;
        acc(1, 8'h01, 4'h0, 2'd1, 32'h1, rd, rq, erd, erq); chk("R7 no req while stuck", {31'd0, rq}, 32'd0);
        do_reset();
        acc(0, 8'h01, 4'h0, 2'd1, 0, rd, rq, erd, erq); chk("R7 reset clears", rd, 32'h0);

        // R8 debug-off and halt
        acc(1, 8'h01, 4'h0, 2'd1, 32'h6, rd, rq, erd, erq); chk("R8 both set", {30'd0, halt_req, debug_off}, 32'h3);
        acc(1, 8'h01, 4'h0, 2'd1, 32'h2, rd, rq, erd, erq); chk("R8 halt cleared", {30'd0, halt_req, debug_off}, 32'h1);

        // R9 secure gating
        secure = 1'b1;
        acc(1, 8'h01, 4'h0, 2'd1, 32'h4, rd, rq, erd, erq); chk("R9 bits held", {30'd0, halt_req, debug_off}, 32'h1);
        acc(1, 8'h01, 4'h0, 2'd1, 32'h1, rd, rq, erd, erq); chk("R9 erase still allowed", {31'd0, rq}, 32'd1);
        acc(0, 8'h01, 4'h0, 2'd0, 0, rd, rq, erd, erq); chk("R10 status secure", rd, 32'h7);
        secure = 1'b0; pulse_done();

        // R2 and R11: other targets
        acc(1, 8'h00, 4'h0, 2'd1, 32'h7, rd, rq, erd, erq);
        acc(1, 8'h02, 4'h0, 2'd1, 32'h7, rd, rq, erd, erq);
        acc(1, 8'h01, 4'h5, 2'd1, 32'h7, rd, rq, erd, erq);
        acc(0, 8'h01, 4'h0, 2'd1, 0, rd, rq, erd, erq); chk("R11 R2 no effect", rd, 32'h2);
        acc(0, 8'h01, 4'h0, 2'd2, 0, rd, rq, erd, erq); chk("R11 unmapped read", rd, 32'h0);
        acc(0, 8'h01, 4'hF, 2'd0, 0, rd, rq, erd, erq); chk("R11 unmapped id bank", rd, 32'h0);
        @(negedge clk); chk("R4 idle rdata", rdata, 32'h0);

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            logic [7:0] p; logic [3:0] b; logic [1:0] a; logic w;
            if (i % 60 == 59) begin
                do_reset(); @(negedge clk);
                chk("R1 random reset", {29'd0, erase_req, debug_off, halt_req}, 32'd0);
            end
            secure       = ($urandom % 3) == 0;
            erase_enable = ($urandom % 2) == 0;
            case ($urandom % 5)
                0: p = 8'h00;
                4: p = 8'($urandom);
                default: p = 8'h01;
            endcase
            case ($urandom % 4)
                0, 1: b = 4'h0;
                2: b = 4'hF;
                default: b = 4'($urandom);
            endcase
            a = 2'($urandom);
            w = ($urandom % 2) == 0;
            acc(w, p, b, a, $urandom, rd, rq, erd, erq);
            chk("R4 R10 R11 random read", rd, erd);
            chk("R5 R7 random req", {31'd0, rq}, {31'd0, erq});
            chk_outs("R8 R9 random outputs");
            if ($urandom % 6 == 0) pulse_done();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule